// File: doc/BRIEF.md
# Burst Duty-Cycle Clock Gate

This block decides, cycle by cycle, whether the processor core clock is let through. A free-running frame counter splits system-clock time into frames of 31 cycles. A 5-bit burst width tells how many cycles at the start of each frame pass to the core, so the core clock rate can be set anywhere from none to all of the system clock. Each width step is about 3% of the system clock. The clock-tree cell that does the gating sits outside the block and takes the `core_clk_en` output.

When the gating controller is armed and either the stop flag is set or the width is zero, the core clock is held off completely. This is the doze state. In doze, only an interrupt request or a hardware reset brings the core clock back. An interrupt disarms the controller, so the core runs at full rate. Software can re-arm the controller at the end of its handler to go back to doze. A separate bit gates the external clock-out reference, and that reference may keep running through doze.

During doze, the block asks for the data-bus pull-ups unless the display controller is using the bus. Width, stop and arm changes are held in pending storage and only apply at a frame boundary. This means a frame is never cut short part-way through.

Top module: `burst_clk_gate`

## Requirements
- R1: While reset is active and just after it ends, core_clk_en=1, clkout_en=1, doze=0 and bus_pullup_en=0. The block resets to width 31, stop clear, controller disarmed and clock-out enabled.
- R2: The frame counter counts 0..30 and wraps, one step per system clock, starting at 0 after reset. When the block is armed with stop clear and width W in 1..30, core_clk_en is 1 when the counter value is below W and 0 otherwise.
- R3: When the block is armed with width 31 and stop clear, core_clk_en stays 1 in every cycle.
- R4: When the controller is disarmed, core_clk_en is 1 in every cycle, whatever the width and stop values are.
- R5: When the block is armed with stop set, or with width 0, core_clk_en is 0 and doze is 1. Both hold until an interrupt or a reset.
- R6: A write pulses cfg_we with cfg_wdata[4:0]=width, [5]=stop, [6]=controller arm and [7]=clock-out enable. Width, stop and arm are held pending. They become active in the first cycle of the next frame, counter value 0. A write made in the last cycle of a frame (counter 30) counts for the frame that follows.
- R7: When irq is 1 at a clock edge, the controller is disarmed at that edge, both its pending and active values. This wins over a write in the same cycle. In the next cycle core_clk_en=1 and doze=0.
- R8: After an interrupt wake, writing the arm bit with stop set puts the block back into doze from the next frame boundary.
- R9: clkout_en takes the written clock-out bit in the cycle after the write. It does not wait for a frame boundary, and it does not depend on doze.
- R10: bus_pullup_en is 1 exactly when doze is 1 and disp_bus_busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Write data: width, stop, arm and clock-out bits |
| irq | input | 1 | Interrupt request, wakes the core |
| disp_bus_busy | input | 1 | Display controller is using the data bus |
| core_clk_en | output | 1 | Enable for the core clock gate |
| clkout_en | output | 1 | Enable for the external clock-out reference |
| doze | output | 1 | Core clock is held fully off |
| bus_pullup_en | output | 1 | Request for the data-bus pull-ups |

## Verification
The bench writes configurations in the middle of a frame and in the last cycle of a frame. A design that applied changes straight away would cut a burst short, and one that ignored a write made at the boundary would run a whole frame late. It goes through widths 1, 30 and 31 to catch off-by-one errors in the compare and in the wrap, which would show up as one extra or one missing enabled cycle per frame. It sends an interrupt in the same cycle as a write that re-arms the controller. A design that let the write win would stay in doze, and the core would never wake. It also changes the bus-busy flag and the clock-out bit during doze, to catch a pull-up request asserted while the bus is in use and a clock-out bit tied to the doze state.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   // Gating mode the combinational decoder reports for the current cycle
   typedef enum logic [1:0] {
      GM_FULL  = 2'd0,   // controller disarmed, every cycle passes
      GM_BURST = 2'd1,   // armed, leading part of each frame passes
      GM_DOZE  = 2'd2    // armed with stop or zero width, nothing passes
   } gate_mode_e;

   // Mode selection from active configuration
   function automatic gate_mode_e pick_mode(input logic armed,
                                            input logic stop,
                                            input logic zero_width);
      if (!armed)
         return GM_FULL;
      else if (stop || zero_width)
         return GM_DOZE;
      else
         return GM_BURST;
   endfunction

endpackage

// File: rtl/bcg_frame_counter.sv
module bcg_frame_counter #(
   parameter int unsigned CNT_W     = 5,
   parameter int unsigned FRAME_LEN = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             frame_last
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   generate
      if (FRAME_LEN < 2 || FRAME_LEN > (1 << CNT_W)) begin : g_bad_len
         $error("bcg_frame_counter: FRAME_LEN out of range for CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc    = cnt + 1'b1;
   assign frame_last = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (frame_last)
         cnt <= '0;
      else
         cnt <= cnt_inc;
   end

   // R2: counter never leaves 0..FRAME_LEN-1
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R2: wrap to zero after the last cycle
   p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_last |=> (cnt == '0));

   // R2: otherwise advance by one
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_last |=> (cnt == $past(cnt_inc)));

endmodule

// File: rtl/bcg_cfg_regs.sv
module bcg_cfg_regs #(
   parameter int unsigned WIDTH_BITS    = 5,
   parameter bit          LOAD_AT_FRAME = 1'b1,
   parameter int unsigned RST_WIDTH     = 31,
   parameter bit          RST_CLKOUT    = 1'b1,
   localparam int unsigned WD_W         = WIDTH_BITS + 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [WD_W-1:0]       wdata,
   input  logic                  irq,
   input  logic                  frame_last,
   output logic [WIDTH_BITS-1:0] act_width,
   output logic                  act_stop,
   output logic                  act_en,
   output logic                  clkout_en
);

   localparam int unsigned       STOP_BIT = WIDTH_BITS;
   localparam int unsigned       EN_BIT   = WIDTH_BITS + 1;
   localparam int unsigned       CKO_BIT  = WIDTH_BITS + 2;
   localparam logic [WIDTH_BITS-1:0] W_RST = WIDTH_BITS'(RST_WIDTH);

   generate
      if (RST_WIDTH >= (1 << WIDTH_BITS)) begin : g_bad_rst
         $error("bcg_cfg_regs: RST_WIDTH does not fit WIDTH_BITS");
      end
   endgenerate

   logic [WIDTH_BITS-1:0] pend_width, pend_width_nxt;
   logic                  pend_stop,  pend_stop_nxt;
   logic                  pend_en,    pend_en_nxt;
   logic                  load_now;

   // Pending values including a write in this cycle; interrupt wins on arm
   always_comb begin
      pend_width_nxt = pend_width;
      pend_stop_nxt  = pend_stop;
      pend_en_nxt    = pend_en;
      if (we) begin
         pend_width_nxt = wdata[WIDTH_BITS-1:0];
         pend_stop_nxt  = wdata[STOP_BIT];
         pend_en_nxt    = wdata[EN_BIT];
      end
      if (irq)
         pend_en_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_width <= W_RST;
         pend_stop  <= 1'b0;
         pend_en    <= 1'b0;
      end else begin
         pend_width <= pend_width_nxt;
         pend_stop  <= pend_stop_nxt;
         pend_en    <= pend_en_nxt;
      end
   end

   // Clock-out enable applies straight away
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         clkout_en <= RST_CLKOUT;
      else if (we)
         clkout_en <= wdata[CKO_BIT];
   end

   // Variant: load at frame boundary, or track every cycle
   generate
      if (LOAD_AT_FRAME) begin : g_frame_load
         assign load_now = frame_last;

         // R6: active burst settings only change on a boundary edge
         p_act_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_last |=> ($stable(act_width) && $stable(act_stop)));
      end else begin : g_direct_load
         assign load_now = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_width <= W_RST;
         act_stop  <= 1'b0;
         act_en    <= 1'b0;
      end else begin
         if (load_now) begin
            act_width <= pend_width_nxt;
            act_stop  <= pend_stop_nxt;
         end
         if (irq)
            act_en <= 1'b0;
         else if (load_now)
            act_en <= pend_en_nxt;
      end
   end

   // R7: interrupt disarms both pending and active arm bits
   p_irq_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> (!act_en && !pend_en));

endmodule

// File: rtl/bcg_gate_logic.sv
module bcg_gate_logic
   import bcg_pkg::*;
#(
   parameter int unsigned WIDTH_BITS = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [WIDTH_BITS-1:0] cnt,
   input  logic [WIDTH_BITS-1:0] act_width,
   input  logic                  act_stop,
   input  logic                  act_en,
   input  logic                  bus_busy,
   output logic                  core_en,
   output logic                  doze,
   output logic                  pullup_en
);

   gate_mode_e mode;
   logic       in_burst;

   // Counter tops out at 2**WIDTH_BITS-2, so full width always passes
   assign in_burst = (cnt < act_width);
   assign mode     = pick_mode(act_en, act_stop, act_width == '0);

   always_comb begin
      unique case (mode)
         GM_FULL:  core_en = 1'b1;
         GM_BURST: core_en = in_burst;
         default:  core_en = 1'b0;
      endcase
   end

   assign doze      = (mode == GM_DOZE);
   assign pullup_en = doze && !bus_busy;

   // R5: doze persists while configuration is untouched by interrupt
   p_doze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (doze && act_en) |=> (doze || !act_en || !$stable(act_width) || !$stable(act_stop)));

endmodule

// File: rtl/burst_clk_gate.sv
module burst_clk_gate #(
   parameter int unsigned WIDTH_BITS    = 5,
   parameter bit          LOAD_AT_FRAME = 1'b1,
   parameter int unsigned RST_WIDTH     = 31,
   parameter bit          RST_CLKOUT    = 1'b1,
   localparam int unsigned WD_W         = WIDTH_BITS + 3,
   localparam int unsigned FRAME_LEN    = (1 << WIDTH_BITS) - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [WD_W-1:0] cfg_wdata,
   input  logic            irq,
   input  logic            disp_bus_busy,
   output logic            core_clk_en,
   output logic            clkout_en,
   output logic            doze,
   output logic            bus_pullup_en
);

   generate
      if (WIDTH_BITS < 2 || WIDTH_BITS > 8) begin : g_bad_bits
         $error("burst_clk_gate: WIDTH_BITS must be 2..8");
      end
   endgenerate

   logic [WIDTH_BITS-1:0] cnt;
   logic                  frame_last;
   logic [WIDTH_BITS-1:0] act_width;
   logic                  act_stop;
   logic                  act_en;

   bcg_frame_counter #(
      .CNT_W     (WIDTH_BITS),
      .FRAME_LEN (FRAME_LEN)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt        (cnt),
      .frame_last (frame_last)
   );

   bcg_cfg_regs #(
      .WIDTH_BITS    (WIDTH_BITS),
      .LOAD_AT_FRAME (LOAD_AT_FRAME),
      .RST_WIDTH     (RST_WIDTH),
      .RST_CLKOUT    (RST_CLKOUT)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .wdata      (cfg_wdata),
      .irq        (irq),
      .frame_last (frame_last),
      .act_width  (act_width),
      .act_stop   (act_stop),
      .act_en     (act_en),
      .clkout_en  (clkout_en)
   );

   bcg_gate_logic #(
      .WIDTH_BITS (WIDTH_BITS)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .act_width (act_width),
      .act_stop  (act_stop),
      .act_en    (act_en),
      .bus_busy  (disp_bus_busy),
      .core_en   (core_clk_en),
      .doze      (doze),
      .pullup_en (bus_pullup_en)
   );

   // R7: an interrupt always brings the core clock back next cycle
   p_irq_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> (core_clk_en && !doze));

   // R10: pull-up request never while the display owns the bus
   p_pullup_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      disp_bus_busy |-> !bus_pullup_en);

endmodule

// File: tb/tb_burst_clk_gate.sv
module tb_burst_clk_gate;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'd0;
   logic       irq = 1'b0;
   logic       disp_bus_busy = 1'b0;
   logic       core_clk_en, clkout_en, doze, bus_pullup_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   string cur_tag = "R1";

   // Reference model state
   int m_cnt, m_pw, m_aw;
   bit m_ps, m_pe, m_as, m_ae, m_ck;

   always #10 clk = ~clk;   // 50 MHz

   burst_clk_gate dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_wdata     (cfg_wdata),
      .irq           (irq),
      .disp_bus_busy (disp_bus_busy),
      .core_clk_en   (core_clk_en),
      .clkout_en     (clkout_en),
      .doze          (doze),
      .bus_pullup_en (bus_pullup_en)
   );

   task automatic check(input string tag, input string what,
                        input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, actual, expected, $time);
      end
   endtask

   // Behavioural model, updated at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pw = 31; m_aw = 31;
         m_ps = 0; m_pe = 0; m_as = 0; m_ae = 0; m_ck = 1;
      end else begin
         int nw; bit ns, ne;
         nw = m_pw; ns = m_ps; ne = m_pe;
         if (cfg_we) begin
            nw = cfg_wdata[4:0]; ns = cfg_wdata[5]; ne = cfg_wdata[6]; m_ck = cfg_wdata[7];
         end
         if (irq) ne = 0;
         if (m_cnt == 30) begin m_aw = nw; m_as = ns; m_ae = ne; end
         if (irq) m_ae = 0;
         m_pw = nw; m_ps = ns; m_pe = ne;
         m_cnt = (m_cnt == 30) ? 0 : m_cnt + 1;
      end
   end

   // Compare every cycle, a quarter period after the rising edge
   always @(posedge clk) begin
      #5;
      if (!done) begin
         bit e_doze, e_core;
         e_doze = m_ae && (m_as || m_aw == 0);
         e_core = !m_ae ? 1'b1 : (e_doze ? 1'b0 : (m_cnt < m_aw));
         check(cur_tag, "core_clk_en", int'(core_clk_en), int'(e_core));
         check(cur_tag, "doze", int'(doze), int'(e_doze));
         check(cur_tag, "clkout_en", int'(clkout_en), int'(m_ck));
         check(cur_tag, "bus_pullup_en", int'(bus_pullup_en), int'(e_doze && !disp_bus_busy));
      end
   end

   task automatic wr(input int w, input bit st, input bit en, input bit ck);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = {ck, en, st, 5'(w)};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Wait until the model counter reads the given value (just after a negedge)
   task automatic to_cnt(input int c);
      @(negedge clk);
      while (m_cnt != c) @(negedge clk);
   endtask

   initial begin
      // R1: reset values
      cur_tag = "R1";
      idle(3);
      check("R1", "core_clk_en in reset", int'(core_clk_en), 1);
      check("R1", "clkout_en in reset", int'(clkout_en), 1);
      check("R1", "doze in reset", int'(doze), 0);
      rst_n = 1'b1;
      idle(4);

      // R4: disarmed ignores width and stop
      cur_tag = "R4";
      wr(5, 1, 0, 1);
      idle(70);
      check("R4", "core_clk_en disarmed", int'(core_clk_en), 1);

      // R6: mid-frame write waits for boundary
      cur_tag = "R6";
      to_cnt(12);
      wr(10, 0, 1, 1);
      check("R6", "core_clk_en before boundary", int'(core_clk_en), 1);
      to_cnt(0);

      // R2: several widths
      cur_tag = "R2";
      idle(70);
      to_cnt(30);
      cur_tag = "R6";
      cfg_we = 1'b1; cfg_wdata = {1'b1, 1'b1, 1'b0, 5'd1};   // write in last cycle
      @(negedge clk); cfg_we = 1'b0;
      cur_tag = "R2";
      idle(70);
      wr(30, 0, 1, 1);
      idle(70);

      // R3: full width
      cur_tag = "R3";
      wr(31, 0, 1, 1);
      idle(70);

      // R5: stop, then zero width
      cur_tag = "R5";
      wr(12, 1, 1, 1);
      idle(70);
      check("R5", "doze with stop", int'(doze), 1);
      cur_tag = "R10";
      disp_bus_busy = 1'b1; idle(5);
      disp_bus_busy = 1'b0; idle(5);

      // R9: clock-out bit during doze
      cur_tag = "R9";
      wr(12, 1, 1, 0);
      check("R9", "clkout_en cleared", int'(clkout_en), 0);
      idle(10);
      wr(12, 1, 1, 1);
      idle(5);

      // R7: interrupt wake
      cur_tag = "R7";
      @(negedge clk); irq = 1'b1;
      @(negedge clk); irq = 1'b0;
      check("R7", "core_clk_en after irq", int'(core_clk_en), 1);
      idle(40);

      // R5: zero width doze
      cur_tag = "R5";
      wr(0, 0, 1, 1);
      idle(70);

      // R7: irq beats a same-cycle arm write
      cur_tag = "R7";
      @(negedge clk); irq = 1'b1; cfg_we = 1'b1; cfg_wdata = {1'b1, 1'b1, 1'b1, 5'd8};
      @(negedge clk); irq = 1'b0; cfg_we = 1'b0;
      idle(70);
      check("R7", "doze after irq+write", int'(doze), 0);

      // R8: re-arm after wake
      cur_tag = "R8";
      wr(20, 1, 1, 1);
      idle(70);
      check("R8", "doze after re-arm", int'(doze), 1);
      cur_tag = "R10";
      disp_bus_busy = 1'b1; idle(3);
      check("R10", "pullup while busy", int'(bus_pullup_en), 0);
      disp_bus_busy = 1'b0; idle(3);
      check("R10", "pullup while idle bus", int'(bus_pullup_en), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog expired t=%0t", $time);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule